// File: doc/BRIEF.md
# Age-Ordered Issue Queue

This block keeps a small set of dispatched instructions, each tagged with an index. Every entry is in one of three live pools: waiting for operands, ready to issue, or executing. A dispatch request puts the entry into the ready pool if its operands are already available, and into the waiting pool otherwise. A per-slot wakeup moves a waiting entry to ready. A resource grant issues the oldest ready entry, which then stays in the executing pool until a writeback names its index.

Every cycle the block also returns an admission code for the current dispatch request. The code says whether the request can be accepted. If it cannot, the code gives the reason: no free slot, the in-order group resource is busy, the load queue is full, or the store queue is full. A dispatch is only accepted when the code is zero. Age is compared modulo the index width, so the order stays correct when the index counter wraps. This requires the live indices to span less than half the index range.

Top module: `issue_queue`

## Requirements
- R1: After reset every slot is free (state 0), `iss_valid` is low, and `adm_code` is 0 when no stall input is active.
- R2: An accepted dispatch goes into the lowest-numbered free slot. On the next clock edge that slot reads 2 (ready) if `disp_opnd_ok` was high, or 1 (waiting) otherwise. The state of slot s is `ent_state[2s+1:2s]`.
- R3: A high `wake[s]` while slot s is waiting makes that slot ready at the next edge. `wake[s]` has no effect on a slot that is free, ready or executing.
- R4: While `res_grant` is high and at least one slot is ready, `iss_valid` is high in the same cycle and `iss_idx` carries the index of the oldest ready entry. At the next edge that entry's slot reads 3 (executing). At most one entry issues per cycle.
- R5: While `res_grant` is low, `iss_valid` is low and no ready entry changes state.
- R6: A `wb_valid` with `wb_idx` equal to the index of an executing entry frees that slot at the next edge. A writeback that matches no executing entry changes nothing.
- R7: `adm_code` takes the first of these that applies: 1 when no slot is free; 2 when `disp_grp` and `grp_busy` are both high; 3 when `disp_load` and `ldq_full` are both high; 4 when `disp_store` and `stq_full` are both high; 0 otherwise. A load-queue stall never applies to a request without `disp_load`, and a store-queue stall never applies to a request without `disp_store`.
- R8: A dispatch request made while `adm_code` is not 0 leaves every slot state unchanged.
- R9: Age is compared modulo 2^IDXW. An index is older than another when their wrapped difference is negative, so with IDXW=4, index 14 issues before index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | IDXW | Index of the dispatched instruction |
| disp_opnd_ok | input | 1 | Operands already available |
| disp_load | input | 1 | Request may load |
| disp_store | input | 1 | Request may store |
| disp_grp | input | 1 | Request uses the in-order group resource |
| grp_busy | input | 1 | In-order group resource not free |
| ldq_full | input | 1 | Load queue full |
| stq_full | input | 1 | Store queue full |
| wake | input | DEPTH | Per-slot operand/memory readiness |
| res_grant | input | 1 | Execution resource available this cycle |
| wb_valid | input | 1 | Writeback completion |
| wb_idx | input | IDXW | Index of the completing instruction |
| iss_valid | output | 1 | Issue strobe |
| iss_idx | output | IDXW | Index issued, meaningful only with `iss_valid` |
| ent_state | output | 2*DEPTH | Per-slot state: 0 free, 1 waiting, 2 ready, 3 executing |
| adm_code | output | 3 | Admission code for the current request |

## Verification
A wrong slot state shows on `ent_state` one edge after the dispatch, wakeup, issue or writeback that caused it. A wrong age choice shows on `iss_idx` in the cycle of the grant. It also leaves the wrong slot executing at the next edge, which the later issue order shows as well. Admission priority is combinational and shows on `adm_code` in the same cycle as the request. A dispatch that is accepted when it should not be shows as a changed slot one edge later.

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [IDXW-1:0]      disp_idx,
  input  logic                 disp_opnd_ok,
  input  logic                 disp_load,
  input  logic                 disp_store,
  input  logic                 disp_grp,
  input  logic                 grp_busy,
  input  logic                 ldq_full,
  input  logic                 stq_full,
  input  logic [DEPTH-1:0]     wake,
  input  logic                 res_grant,
  input  logic                 wb_valid,
  input  logic [IDXW-1:0]      wb_idx,
  output logic                 iss_valid,
  output logic [IDXW-1:0]      iss_idx,
  output logic [2*DEPTH-1:0]   ent_state,
  output logic [2:0]           adm_code
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] S_FREE = 2'd0, S_WAIT = 2'd1, S_RDY = 2'd2, S_EXE = 2'd3;

  logic [1:0]      st  [DEPTH];
  logic [IDXW-1:0] tag [DEPTH];
  logic [DEPTH-1:0] free_v, rdy_v;
  logic [SW-1:0]   alloc_slot, sel_slot;
  logic            sel_found;
  logic [IDXW-1:0] sel_tag;
  logic            accept;

  function automatic logic older(input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
    logic [IDXW-1:0] d;
    d = a - b;
    return d[IDXW-1];
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign free_v[g]          = (st[g] == S_FREE);
    assign rdy_v[g]           = (st[g] == S_RDY);
    assign ent_state[2*g +: 2] = st[g];
  end

  always_comb begin
    alloc_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_v[i]) alloc_slot = SW'(i);
  end

  always_comb begin
    sel_found = 1'b0;
    sel_slot  = '0;
    sel_tag   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rdy_v[i] && (!sel_found || older(tag[i], sel_tag))) begin
        sel_found = 1'b1;
        sel_slot  = SW'(i);
        sel_tag   = tag[i];
      end
  end

  assign iss_valid = res_grant && sel_found;
  assign iss_idx   = sel_tag;

  always_comb begin
    if (free_v == '0)                 adm_code = 3'd1;
    else if (disp_grp && grp_busy)    adm_code = 3'd2;
    else if (disp_load && ldq_full)   adm_code = 3'd3;
    else if (disp_store && stq_full)  adm_code = 3'd4;
    else                              adm_code = 3'd0;
  end

  assign accept = disp_valid && (adm_code == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i]  <= S_FREE;
        tag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        case (st[i])
          S_FREE: if (accept && alloc_slot == SW'(i)) begin
            st[i]  <= disp_opnd_ok ? S_RDY : S_WAIT;
            tag[i] <= disp_idx;
          end
          S_WAIT: if (wake[i]) st[i] <= S_RDY;
          S_RDY:  if (iss_valid && sel_slot == SW'(i)) st[i] <= S_EXE;
          default: if (wb_valid && tag[i] == wb_idx) st[i] <= S_FREE;
        endcase
      end
    end
  end
endmodule

// File: rtl/issue_queue_chk.sv
module issue_queue_chk #(
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               res_grant,
  input logic [2*DEPTH-1:0] ent_state,
  input logic [2:0]         adm_code,
  input logic               disp_grp,
  input logic               grp_busy,
  input logic               disp_load,
  input logic               ldq_full,
  input logic               disp_store,
  input logic               stq_full
);
  logic any_ready, none_free;
  always_comb begin
    any_ready = 1'b0;
    none_free = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_state[2*i +: 2] == 2'd2) any_ready = 1'b1;
      if (ent_state[2*i +: 2] == 2'd0) none_free = 1'b0;
    end
  end

  AST_ISSUE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) iss_valid |-> res_grant); // R5
  AST_ISSUE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) iss_valid |-> any_ready); // R4
  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (res_grant && any_ready) |-> iss_valid); // R4
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) adm_code <= 3'd4); // R7
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n) none_free |-> adm_code == 3'd1); // R7
  AST_GROUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) adm_code == 3'd2 |-> (disp_grp && grp_busy)); // R7
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) adm_code == 3'd3 |-> (disp_load && ldq_full)); // R7
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) adm_code == 3'd4 |-> (disp_store && stq_full)); // R7
endmodule

bind issue_queue issue_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_issue_queue.sv
module tb_issue_queue;
  localparam int DEPTH = 8;
  localparam int IDXW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 0, disp_opnd_ok = 0, disp_load = 0, disp_store = 0, disp_grp = 0;
  logic grp_busy = 0, ldq_full = 0, stq_full = 0, res_grant = 0, wb_valid = 0;
  logic [IDXW-1:0] disp_idx = '0, wb_idx = '0;
  logic [DEPTH-1:0] wake = '0;
  logic iss_valid;
  logic [IDXW-1:0] iss_idx;
  logic [2*DEPTH-1:0] ent_state;
  logic [2:0] adm_code;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  issue_queue #(.DEPTH(DEPTH), .IDXW(IDXW)) dut (.*);

  // {load, store, grp, grp_busy, ldq_full, stq_full, code[2:0]}
  localparam logic [8:0] ADM_TAB [11] = '{
    {6'b000000, 3'd0}, {6'b001100, 3'd2}, {6'b001000, 3'd0}, {6'b101110, 3'd2},
    {6'b100010, 3'd3}, {6'b010001, 3'd4}, {6'b010010, 3'd0}, {6'b100001, 3'd0},
    {6'b110011, 3'd3}, {6'b000011, 3'd0}, {6'b011101, 3'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot(input int s);
    return int'(ent_state[2*s +: 2]);
  endfunction

  task automatic idle();
    disp_valid = 0; disp_opnd_ok = 0; disp_load = 0; disp_store = 0; disp_grp = 0;
    grp_busy = 0; ldq_full = 0; stq_full = 0; res_grant = 0; wb_valid = 0; wake = '0;
  endtask

  task automatic edge_();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic disp(input int idx, input logic rdy);
    disp_valid = 1; disp_idx = IDXW'(idx); disp_opnd_ok = rdy;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    for (int s = 0; s < DEPTH; s++) chk("R1 state", slot(s), 0);
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 adm_code", int'(adm_code), 0);

    // R7 admission table, no dispatch
    for (int k = 0; k < 11; k++) begin
      {disp_load, disp_store, disp_grp, grp_busy, ldq_full, stq_full} = ADM_TAB[k][8:3];
      #1 chk("R7 code", int'(adm_code), int'(ADM_TAB[k][2:0]));
      idle();
    end

    // R8 rejected dispatch
    disp(2, 1); disp_load = 1; ldq_full = 1;
    #1 chk("R8 code", int'(adm_code), 3);
    edge_();
    chk("R8 slot0 unchanged", slot(0), 0);

    // R2 dispatch
    disp(5, 1); edge_(); chk("R2 slot0 ready", slot(0), 2);
    disp(3, 1); edge_(); chk("R2 slot1 ready", slot(1), 2);
    disp(7, 0); edge_(); chk("R2 slot2 waiting", slot(2), 1);

    // R4 oldest first; R3 wake on free/ready ignored
    res_grant = 1; wake[3] = 1; wake[0] = 1;
    #1 chk("R4 iss_valid", int'(iss_valid), 1);
    chk("R4 iss_idx oldest", int'(iss_idx), 3);
    edge_();
    chk("R4 slot1 exec", slot(1), 3);
    chk("R3 slot0 ready kept", slot(0), 2);
    chk("R3 slot3 free kept", slot(3), 0);

    res_grant = 1; wb_valid = 1; wb_idx = 3;
    #1 chk("R4 iss_idx next", int'(iss_idx), 5);
    edge_();
    chk("R6 slot1 freed", slot(1), 0);
    chk("R4 slot0 exec", slot(0), 3);

    // R3 wake waiting slot; not issued same cycle
    wake[2] = 1; res_grant = 1;
    #1 chk("R4 no ready no issue", int'(iss_valid), 0);
    edge_();
    chk("R3 slot2 ready", slot(2), 2);

    // R5 no grant
    #1 chk("R5 iss_valid low", int'(iss_valid), 0);
    edge_();
    chk("R5 slot2 kept ready", slot(2), 2);

    res_grant = 1; wb_valid = 1; wb_idx = 9;
    #1 chk("R4 iss_idx 7", int'(iss_idx), 7);
    edge_();
    chk("R4 slot2 exec", slot(2), 3);
    chk("R6 mismatch ignored", slot(0), 3);

    wb_valid = 1; wb_idx = 5; edge_();
    wb_valid = 1; wb_idx = 7; edge_();
    chk("R6 slot0 freed", slot(0), 0);
    chk("R6 slot2 freed", slot(2), 0);

    // R9 wraparound
    disp(1, 1); edge_();
    disp(14, 1); edge_();
    res_grant = 1;
    #1 chk("R9 wrapped older first", int'(iss_idx), 14);
    edge_();
    chk("R9 slot1 exec", slot(1), 3);
    res_grant = 1;
    #1 chk("R9 then index 1", int'(iss_idx), 1);
    edge_();
    wb_valid = 1; wb_idx = 14; edge_();
    wb_valid = 1; wb_idx = 1; edge_();
    chk("R6 all free", int'(ent_state), 0);

    // R7 full queue priority, R8 rejected while full
    for (int i = 0; i < DEPTH; i++) begin disp(i, 0); edge_(); end
    for (int s = 0; s < DEPTH; s++) chk("R2 waiting fill", slot(s), 1);
    disp(9, 1); disp_grp = 1; grp_busy = 1; disp_load = 1; ldq_full = 1;
    #1 chk("R7 full first", int'(adm_code), 1);
    edge_();
    for (int s = 0; s < DEPTH; s++) chk("R8 full unchanged", slot(s), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule